// File: doc/BRIEF.md
# Push-Button Event Port

This block is a small memory-mapped input port for a bank of push-buttons. It samples the button levels every clock and records each completed press-and-release of a button in a sticky per-button event bit. Software reads the levels and the recorded events through a simple synchronous word bus. It clears events by writing ones to them and picks which buttons may interrupt through a mask word.

The single interrupt request output is high whenever a recorded event has its mask bit set. It stays high until software clears that event or masks it off. The button inputs are assumed to be already synchronised to the clock and free of bounce. A level of 1 means pressed.

The bus selects one of four 32-bit words with a 2-bit word index. Word 0 holds the levels, word 1 is a direction word that this input-only port does not use, word 2 is the interrupt mask and word 3 holds the events. Read data is registered: it appears on the data output after the clock edge that accepts the read and holds until the next read.

Top module: `btn_event_port`

## Requirements
- R1: A read of word 0 returns the button levels sampled at the accepting edge in bits [3:0], with 0 in the upper bits. A write to word 0 changes nothing.
- R2: Word 2 (mask) stores bits [3:0] of a write. A read of word 2 or word 3 returns 0 in bits [31:4].
- R3: When a button's sampled level is 1 on one edge and 0 on the next, its event bit in word 3 is set at that second edge. A press alone sets nothing. A set event bit stays set until it is cleared.
- R4: A write to word 3 clears every event bit whose write-data bit is 1 and leaves the others unchanged. Writing 0xF clears all four.
- R5: If a release and a clearing write hit the same event bit at the same edge, the bit ends up set.
- R6: The interrupt output is 1 exactly when some event bit and its mask bit are both 1. It follows register changes in the same cycle and stays high until the event is cleared or masked.
- R7: Word 1 (direction) always reads 0, and writes to it have no effect.
- R8: Reset (active low, synchronous) clears the mask, the events, the previous-level history and the read data, so the interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| key_level_i | input | 4 | Button levels, 1 = pressed |
| bus_sel_i | input | 1 | Bus access strobe for this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_word_i | input | 2 | Word index (byte offset / 4) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
Each stimulus is driven on a falling edge, and its effect is sampled on the next falling edge, after exactly one rising edge. A read result is due one edge after the read. An event bit and the interrupt are due on the same edge that sees the release, because the previous level is already registered. A mask or clear write acts on the interrupt at the edge that takes the write. The vector table checks only the reads whose data is due in that step. Reads that would race a same-edge event update are skipped, and the bit is read back a step later.

// File: rtl/btn_port_pkg.sv
// Shared constants and word-index encoding for the push-button event port.
// Assumes a 2-bit word index selecting four words.
package btn_port_pkg;
    localparam int KEY_COUNT  = 4;
    localparam int WORD_WIDTH = 32;

    typedef enum logic [1:0] {
        WORD_LEVEL = 2'd0,
        WORD_DIR   = 2'd1,
        WORD_MASK  = 2'd2,
        WORD_EVENT = 2'd3
    } word_sel_e;
endpackage

// File: rtl/btn_release_detect.sv
// Per-button release detector: flags a cycle where the level falls from 1 to 0.
// Assumes clean, synchronised inputs; one history flop per button.
module btn_release_detect #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level_i,
    output logic [N-1:0] release_o
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_key
            logic prev_q;
            // Remember the level seen on the previous edge.
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= level_i[g];
            end
            // A release is pressed-then-not-pressed.
            assign release_o[g] = prev_q & ~level_i[g];
        end
    endgenerate
endmodule

// File: rtl/btn_event_store.sv
// Sticky per-button event bits: set by a release, cleared by write-one.
// A set and a clear in the same cycle leave the bit set.
module btn_event_store #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] cap_o
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            logic cap_q;
            // Set wins over clear; otherwise hold.
            always_ff @(posedge clk) begin
                if (!rst_n)         cap_q <= 1'b0;
                else if (set_i[g])  cap_q <= 1'b1;
                else if (clr_i[g])  cap_q <= 1'b0;
            end
            assign cap_o[g] = cap_q;
        end
    endgenerate
endmodule

// File: rtl/btn_bus_regs.sv
// Bus side: mask storage, write-one-clear decode and registered read mux.
// Assumes one access per cycle; direction word is read-as-zero.
module btn_bus_regs
    import btn_port_pkg::*;
#(
    parameter int N  = 4,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_i,
    input  logic          wr_i,
    input  logic [1:0]    word_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [N-1:0]  level_i,
    input  logic [N-1:0]  cap_i,
    output logic [N-1:0]  mask_o,
    output logic [N-1:0]  clr_o,
    output logic [DW-1:0] rdata_o
);
    localparam int PAD = DW - N;

    logic          wr_stb;
    logic          rd_stb;
    logic [N-1:0]  mask_q;
    logic [DW-1:0] rdata_q;
    logic [N-1:0]  rd_lo;
    logic          unused_wdata_hi;

    assign wr_stb          = sel_i & wr_i;
    assign rd_stb          = sel_i & ~wr_i;
    assign unused_wdata_hi = ^wdata_i[DW-1:N];

    // Mask word keeps only the implemented low bits.
    always_ff @(posedge clk) begin
        if (!rst_n)                              mask_q <= '0;
        else if (wr_stb && word_i == WORD_MASK)  mask_q <= wdata_i[N-1:0];
    end

    // Write-one-clear strobes for the event word.
    always_comb begin
        clr_o = '0;
        if (wr_stb && word_i == WORD_EVENT) clr_o = wdata_i[N-1:0];
    end

    // Select the implemented bits of the addressed word.
    always_comb begin
        case (word_i)
            WORD_LEVEL: rd_lo = level_i;
            WORD_MASK:  rd_lo = mask_q;
            WORD_EVENT: rd_lo = cap_i;
            default:    rd_lo = '0;
        endcase
    end

    // Register read data on an accepted read; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_stb) rdata_q <= {{PAD{1'b0}}, rd_lo};
    end

    assign mask_o  = mask_q;
    assign rdata_o = rdata_q;
endmodule

// File: rtl/btn_irq_gate.sv
// Interrupt combine: OR of events that have their mask bit set.
// Purely combinational from registered state.
module btn_irq_gate #(
    parameter int N = 4
) (
    input  logic [N-1:0] cap_i,
    input  logic [N-1:0] mask_i,
    output logic         irq_o
);
    // Any enabled pending event requests service.
    always_comb irq_o = |(cap_i & mask_i);
endmodule

// File: rtl/btn_event_port.sv
// Top: push-button event port with level, direction, mask and event words.
// Assumes synchronised, debounced active-high button levels.
module btn_event_port
    import btn_port_pkg::*;
#(
    parameter int NUM_KEYS = KEY_COUNT,
    parameter int DATA_W   = WORD_WIDTH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_KEYS-1:0] key_level_i,
    input  logic                bus_sel_i,
    input  logic                bus_wr_i,
    input  logic [1:0]          bus_word_i,
    input  logic [DATA_W-1:0]   bus_wdata_i,
    output logic [DATA_W-1:0]   bus_rdata_o,
    output logic                irq_o
);
    logic [NUM_KEYS-1:0] release_w;
    logic [NUM_KEYS-1:0] clr_w;
    logic [NUM_KEYS-1:0] cap_q;
    logic [NUM_KEYS-1:0] mask_q;

    btn_release_detect #(.N(NUM_KEYS)) u_rel (
        .clk(clk), .rst_n(rst_n), .level_i(key_level_i), .release_o(release_w)
    );

    btn_event_store #(.N(NUM_KEYS)) u_evt (
        .clk(clk), .rst_n(rst_n), .set_i(release_w), .clr_i(clr_w), .cap_o(cap_q)
    );

    btn_bus_regs #(.N(NUM_KEYS), .DW(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel_i(bus_sel_i), .wr_i(bus_wr_i),
        .word_i(bus_word_i), .wdata_i(bus_wdata_i), .level_i(key_level_i),
        .cap_i(cap_q), .mask_o(mask_q), .clr_o(clr_w), .rdata_o(bus_rdata_o)
    );

    btn_irq_gate #(.N(NUM_KEYS)) u_irq (
        .cap_i(cap_q), .mask_i(mask_q), .irq_o(irq_o)
    );
endmodule

// File: rtl/btn_event_port_chk.sv
// Property checker for the push-button event port, bound to the top.
module btn_event_port_chk #(
    parameter int N  = 4,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  key_level,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [1:0]    bus_word,
    input logic [N-1:0]  wdata_lo,
    input logic [DW-1:0] bus_rdata,
    input logic          irq,
    input logic [N-1:0]  cap_q,
    input logic [N-1:0]  mask_q,
    input logic [N-1:0]  release_w
);
    logic clr_wr;
    logic rd_any;
    assign clr_wr = bus_sel && bus_wr && bus_word == 2'd3;
    assign rd_any = bus_sel && !bus_wr;

    p_level_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && bus_word == 2'd0) |=> (bus_rdata[N-1:0] == $past(key_level)));

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_any |=> (bus_rdata[DW-1:N] == '0));

    p_release_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (release_w != '0) |=> ((cap_q & $past(release_w)) == $past(release_w)));

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((cap_q & $past(cap_q)) == $past(cap_q)));

    p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cap_q & ~($past(cap_q) | $past(release_w))) == '0));

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && release_w == '0) |=> (cap_q == ($past(cap_q) & ~$past(wdata_lo))));

    p_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && release_w != '0) |=> ((cap_q & $past(release_w)) == $past(release_w)));

    p_irq_needs_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q != '0 && cap_q != '0));

    p_irq_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(bus_sel && bus_wr && bus_word[1])) |=> irq);

    p_dir_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && bus_word == 2'd1) |=> (bus_rdata == '0));
endmodule

bind btn_event_port btn_event_port_chk #(.N(NUM_KEYS), .DW(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .key_level(key_level_i), .bus_sel(bus_sel_i),
    .bus_wr(bus_wr_i), .bus_word(bus_word_i), .wdata_lo(bus_wdata_i[NUM_KEYS-1:0]),
    .bus_rdata(bus_rdata_o), .irq(irq_o), .cap_q(cap_q), .mask_q(mask_q),
    .release_w(release_w)
);

// File: tb/tb_btn_event_port.sv
`timescale 1ns/1ps
module tb_btn_event_port;
    localparam int N  = 4;
    localparam int DW = 32;
    localparam logic [1:0] OP_NOP = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2;

    typedef struct packed {
        logic [3:0]  keys;
        logic [1:0]  op;
        logic [1:0]  word;
        logic [31:0] wdata;
        logic        chk;
        logic [31:0] rd;
        logic        irq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        '{4'h0, OP_RD,  2'd3, 32'h0,        1'b1, 32'h0, 1'b0, 4'd8},
        '{4'h0, OP_WR,  2'd2, 32'hFFFFFFF5, 1'b0, 32'h0, 1'b0, 4'd2},
        '{4'h0, OP_RD,  2'd2, 32'h0,        1'b1, 32'h5, 1'b0, 4'd2},
        '{4'h3, OP_RD,  2'd0, 32'h0,        1'b1, 32'h3, 1'b0, 4'd1},
        '{4'h3, OP_RD,  2'd3, 32'h0,        1'b1, 32'h0, 1'b0, 4'd3},
        '{4'h1, OP_NOP, 2'd0, 32'h0,        1'b0, 32'h0, 1'b0, 4'd3},
        '{4'h1, OP_RD,  2'd3, 32'h0,        1'b1, 32'h2, 1'b0, 4'd6},
        '{4'h0, OP_NOP, 2'd0, 32'h0,        1'b0, 32'h0, 1'b1, 4'd6},
        '{4'h0, OP_RD,  2'd3, 32'h0,        1'b1, 32'h3, 1'b1, 4'd3},
        '{4'h0, OP_WR,  2'd0, 32'hF,        1'b0, 32'h0, 1'b1, 4'd1},
        '{4'h0, OP_RD,  2'd0, 32'h0,        1'b1, 32'h0, 1'b1, 4'd1},
        '{4'h0, OP_WR,  2'd1, 32'hFFFFFFFF, 1'b0, 32'h0, 1'b1, 4'd7},
        '{4'h0, OP_RD,  2'd1, 32'h0,        1'b1, 32'h0, 1'b1, 4'd7},
        '{4'h0, OP_WR,  2'd3, 32'h2,        1'b0, 32'h0, 1'b1, 4'd4},
        '{4'h0, OP_RD,  2'd3, 32'h0,        1'b1, 32'h1, 1'b1, 4'd4},
        '{4'h0, OP_WR,  2'd3, 32'h1,        1'b0, 32'h0, 1'b0, 4'd4},
        '{4'h0, OP_RD,  2'd3, 32'h0,        1'b1, 32'h0, 1'b0, 4'd4},
        '{4'h4, OP_NOP, 2'd0, 32'h0,        1'b0, 32'h0, 1'b0, 4'd3},
        '{4'h0, OP_WR,  2'd3, 32'h4,        1'b0, 32'h0, 1'b1, 4'd5},
        '{4'h0, OP_RD,  2'd3, 32'h0,        1'b1, 32'h4, 1'b1, 4'd5},
        '{4'h0, OP_WR,  2'd2, 32'h0,        1'b0, 32'h0, 1'b0, 4'd6},
        '{4'h0, OP_RD,  2'd3, 32'h0,        1'b1, 32'h4, 1'b0, 4'd3},
        '{4'hF, OP_NOP, 2'd0, 32'h0,        1'b0, 32'h0, 1'b0, 4'd3},
        '{4'h0, OP_NOP, 2'd0, 32'h0,        1'b0, 32'h0, 1'b0, 4'd6},
        '{4'h0, OP_RD,  2'd3, 32'h0,        1'b1, 32'hF, 1'b0, 4'd3},
        '{4'h0, OP_WR,  2'd3, 32'hF,        1'b0, 32'h0, 1'b0, 4'd4},
        '{4'h0, OP_RD,  2'd3, 32'h0,        1'b1, 32'h0, 1'b0, 4'd4},
        '{4'h0, OP_WR,  2'd2, 32'hF,        1'b0, 32'h0, 1'b0, 4'd6},
        '{4'h0, OP_RD,  2'd2, 32'h0,        1'b1, 32'hF, 1'b0, 4'd2}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  key_level = '0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [1:0]    bus_word = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq;
    int            n_checks = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    btn_event_port dut (
        .clk(clk), .rst_n(rst_n), .key_level_i(key_level), .bus_sel_i(bus_sel),
        .bus_wr_i(bus_wr), .bus_word_i(bus_word), .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata), .irq_o(irq)
    );

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] k, input logic [1:0] op,
                         input logic [1:0] w, input logic [31:0] d);
        key_level = k;
        bus_sel   = (op != OP_NOP);
        bus_wr    = (op == OP_WR);
        bus_word  = w;
        bus_wdata = d;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset irq", {31'b0, irq}, 32'h0);
        check("R8 reset rdata", bus_rdata, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].keys, VECS[i].op, VECS[i].word, VECS[i].wdata);
            tick();
            if (VECS[i].chk)
                check($sformatf("%s vec %0d rdata", req_name(VECS[i].req), i),
                      bus_rdata, VECS[i].rd);
            check($sformatf("%s vec %0d irq", req_name(VECS[i].req), i),
                  {31'b0, irq}, {31'b0, VECS[i].irq});
        end

        // R6: with mask 0xF, a release of button 3 keeps irq high while idle.
        drive(4'h8, OP_NOP, 2'd0, 32'h0); tick();
        drive(4'h0, OP_NOP, 2'd0, 32'h0); tick();
        for (int c = 0; c < 8; c++) begin
            tick();
            check("R6 irq held while pending", {31'b0, irq}, 32'h1);
        end

        // R8: reset in mid-run clears irq, read data, mask and events.
        rst_n = 1'b0; tick();
        check("R8 irq after reset", {31'b0, irq}, 32'h0);
        check("R8 rdata after reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        drive(4'h0, OP_RD, 2'd2, 32'h0); tick();
        check("R8 mask after reset", bus_rdata, 32'h0);
        drive(4'h0, OP_RD, 2'd3, 32'h0); tick();
        check("R8 events after reset", bus_rdata, 32'h0);

        // R3: press held across cycles then released once sets only that bit.
        drive(4'h2, OP_NOP, 2'd0, 32'h0); tick();
        drive(4'h2, OP_NOP, 2'd0, 32'h0); tick();
        drive(4'h0, OP_NOP, 2'd0, 32'h0); tick();
        drive(4'h0, OP_RD, 2'd3, 32'h0); tick();
        check("R3 single release", bus_rdata, 32'h2);
        check("R6 unmasked event no irq", {31'b0, irq}, 32'h0);
        drive(4'h0, OP_NOP, 2'd0, 32'h0); tick();

        done = 1'b1;
        finish_run();
    end
endmodule